// File: doc/BRIEF.md
# Mode-Aware Integer Multiplier with High-Half Results

This block is the integer multiply unit of a core that can run with either 32-bit or 64-bit integer registers. It takes two 64-bit register values, an operation code and the current width mode. It returns one of four results: the low product, the signed upper half, the unsigned upper half, or a 32-bit word product. Results that belong to 32-bit mode are sign-extended to the full register width. That way the register file always holds a canonical value, whichever mode produced it.

The datapath is a three-stage pipeline with a fixed latency. The first stage forms four partial products from the operand halves. The second stage sums them into a 128-bit product. The third stage picks and formats the result. A new operation can be issued on every clock cycle, and every issue returns exactly three cycles later. In 32-bit mode, the upper-half operations take bits 63:32 of the 64-bit product of the full register values; they do not take the top of a 128-bit product. The word-multiply operation exists only in 64-bit mode. Issuing it in 32-bit mode raises an illegal-instruction flag with the same timing as an ordinary result.

Top module: `mulh_unit`

## Requirements
- R1: With op_sel = 0 (low product), wide_mode = 1 returns bits 63:0 of the product, and wide_mode = 0 returns bits 31:0 of the product sign-extended to 64 bits.
- R2: With op_sel = 1 (signed high) and wide_mode = 1, the result is bits 127:64 of the 128-bit product of the operands, both taken as two's complement.
- R3: With op_sel = 2 (unsigned high) and wide_mode = 1, the result is bits 127:64 of the 128-bit product of the operands, both taken as unsigned.
- R4: With op_sel = 1 or 2 and wide_mode = 0, the result is bits 63:32 of the 64-bit product of the full 64-bit operand values, sign-extended to 64 bits. Both codes give the same value.
- R5: With op_sel = 3 (word product) and wide_mode = 1, the result is bits 31:0 of the product sign-extended to 64 bits, and out_illegal stays 0.
- R6: With op_sel = 3 and wide_mode = 0, out_illegal is 1 and out_result is zero.
- R7: out_valid equals in_valid from exactly three clock edges earlier, and each result belongs to that issue. An operation is accepted on every cycle, including back-to-back cycles.
- R8: out_illegal is 1 only together with out_valid, and only for the case of R6.
- R9: While rst_n is low, out_valid, out_illegal and out_result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue strobe |
| op_sel | input | 2 | 0 low, 1 signed high, 2 unsigned high, 3 word |
| wide_mode | input | 1 | 1 = 64-bit registers, 0 = 32-bit registers |
| opa | input | 64 | First register operand |
| opb | input | 64 | Second register operand |
| out_valid | output | 1 | Result strobe, three cycles after issue |
| out_result | output | 64 | Formatted result |
| out_illegal | output | 1 | Illegal-instruction flag for the returning operation |

## Verification
The bench builds the block with its default width of 64, so operands are split into 32-bit halves. This brings the full 128-bit signed and unsigned high products within reach, along with the 32-bit-mode extraction of bits 63:32. The random stream switches the width mode and the operation on every issue and inserts idle bubbles, so back-to-back issue and mode changes inside the pipeline are both covered. Directed cases cover the extreme products: the most negative value squared, all ones times all ones, and negative values sign-extended in 32-bit mode, where the unsigned-high code returns a sign-extended result.

// File: rtl/mulh_pkg.sv
package mulh_pkg;
   typedef enum logic [1:0] {
      OP_LOW    = 2'd0,
      OP_HIGH_S = 2'd1,
      OP_HIGH_U = 2'd2,
      OP_WORD   = 2'd3
   } mul_op_e;

   localparam int unsigned NUM_PP = 4;
endpackage

// File: rtl/mulh_ppgen.sv
module mulh_ppgen
   import mulh_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            v_i,
   input  mul_op_e                         op_i,
   input  logic                            wide_i,
   input  logic [XLEN-1:0]                 a_i,
   input  logic [XLEN-1:0]                 b_i,
   output logic                            v_o,
   output mul_op_e                         op_o,
   output logic                            wide_o,
   output logic [NUM_PP-1:0][XLEN+1:0]     pp_o
);
   localparam int unsigned HALF = XLEN / 2;
   localparam int unsigned PPW  = XLEN + 2;

   if (XLEN % 2 != 0) begin : g_bad_width
      $error("mulh_ppgen: XLEN must be even");
   end

   logic sgn;
   assign sgn = (op_i == OP_HIGH_S);

   for (genvar gi = 0; gi < 2; gi++) begin : g_a
      for (genvar gj = 0; gj < 2; gj++) begin : g_b
         logic [HALF:0]  ax;
         logic [HALF:0]  bx;
         logic [PPW-1:0] prod;
         if (gi == 1) begin : g_ahi
            assign ax = {sgn & a_i[XLEN-1], a_i[gi*HALF +: HALF]};
         end else begin : g_alo
            assign ax = {1'b0, a_i[gi*HALF +: HALF]};
         end
         if (gj == 1) begin : g_bhi
            assign bx = {sgn & b_i[XLEN-1], b_i[gj*HALF +: HALF]};
         end else begin : g_blo
            assign bx = {1'b0, b_i[gj*HALF +: HALF]};
         end
         assign prod = $signed({{(HALF+1){ax[HALF]}}, ax}) *
                       $signed({{(HALF+1){bx[HALF]}}, bx});
         always_ff @(posedge clk) begin
            pp_o[gi*2+gj] <= prod;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_o    <= 1'b0;
         op_o   <= OP_LOW;
         wide_o <= 1'b0;
      end else begin
         v_o    <= v_i;
         op_o   <= op_i;
         wide_o <= wide_i;
      end
   end
endmodule

// File: rtl/mulh_accum.sv
module mulh_accum
   import mulh_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            v_i,
   input  mul_op_e                         op_i,
   input  logic                            wide_i,
   input  logic [NUM_PP-1:0][XLEN+1:0]     pp_i,
   output logic                            v_o,
   output mul_op_e                         op_o,
   output logic                            wide_o,
   output logic [2*XLEN-1:0]               prod_o
);
   localparam int unsigned HALF = XLEN / 2;
   localparam int unsigned PPW  = XLEN + 2;
   localparam int unsigned PW   = 2 * XLEN;

   if (PW <= PPW) begin : g_bad_width
      $error("mulh_accum: product width must exceed partial width");
   end

   logic [NUM_PP-1:0][PW-1:0] term;

   for (genvar gk = 0; gk < NUM_PP; gk++) begin : g_term
      localparam int unsigned SH = ((gk / 2) + (gk % 2)) * HALF;
      assign term[gk] = {{(PW-PPW){pp_i[gk][PPW-1]}}, pp_i[gk]} << SH;
   end

   logic [PW-1:0] sum_lo;
   logic [PW-1:0] sum_hi;
   assign sum_lo = term[0] + term[1];
   assign sum_hi = term[2] + term[3];

   always_ff @(posedge clk) begin
      prod_o <= sum_lo + sum_hi;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_o    <= 1'b0;
         op_o   <= OP_LOW;
         wide_o <= 1'b0;
      end else begin
         v_o    <= v_i;
         op_o   <= op_i;
         wide_o <= wide_i;
      end
   end
endmodule

// File: rtl/mulh_format.sv
module mulh_format
   import mulh_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  v_i,
   input  mul_op_e               op_i,
   input  logic                  wide_i,
   input  logic [2*XLEN-1:0]     prod_i,
   output logic                  v_o,
   output logic [XLEN-1:0]       res_o,
   output logic                  ill_o
);
   localparam int unsigned HALF = XLEN / 2;

   function automatic logic [XLEN-1:0] widen(input logic [HALF-1:0] x);
      return {{HALF{x[HALF-1]}}, x};
   endfunction

   logic            ill_d;
   logic [XLEN-1:0] res_d;

   always_comb begin
      ill_d = (op_i == OP_WORD) && !wide_i;
      unique case (op_i)
         OP_LOW:    res_d = wide_i ? prod_i[XLEN-1:0] : widen(prod_i[HALF-1:0]);
         OP_HIGH_S,
         OP_HIGH_U: res_d = wide_i ? prod_i[2*XLEN-1:XLEN]
                                   : widen(prod_i[XLEN-1:HALF]);
         OP_WORD:   res_d = ill_d ? '0 : widen(prod_i[HALF-1:0]);
         default:   res_d = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_o   <= 1'b0;
         res_o <= '0;
         ill_o <= 1'b0;
      end else begin
         v_o   <= v_i;
         res_o <= v_i ? res_d : '0;
         ill_o <= v_i & ill_d;
      end
   end

   p_low_sext_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (v_i && op_i == OP_LOW && !wide_i) |=> (res_o[XLEN-1:HALF] == {HALF{res_o[HALF-1]}}));

   p_high_sext_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (v_i && !wide_i && (op_i == OP_HIGH_S || op_i == OP_HIGH_U))
      |=> (res_o[XLEN-1:HALF] == {HALF{res_o[HALF-1]}}));

   p_word_sext_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (v_i && wide_i && op_i == OP_WORD)
      |=> (!ill_o && res_o[XLEN-1:HALF] == {HALF{res_o[HALF-1]}}));

   p_illegal_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (v_i && !wide_i && op_i == OP_WORD) |=> (ill_o && res_o == '0));
endmodule

// File: rtl/mulh_unit.sv
module mulh_unit
   import mulh_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [1:0]      op_sel,
   input  logic            wide_mode,
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   output logic            out_valid,
   output logic [XLEN-1:0] out_result,
   output logic            out_illegal
);
   localparam int unsigned PPW = XLEN + 2;

   if (XLEN < 16) begin : g_bad_xlen
      $error("mulh_unit: XLEN below 16 is not supported");
   end

   logic                        s1_v, s2_v;
   mul_op_e                     s1_op, s2_op;
   logic                        s1_wide, s2_wide;
   logic [NUM_PP-1:0][PPW-1:0]  s1_pp;
   logic [2*XLEN-1:0]           s2_prod;

   mulh_ppgen #(.XLEN(XLEN)) u_pp (
      .clk(clk), .rst_n(rst_n), .v_i(in_valid), .op_i(mul_op_e'(op_sel)),
      .wide_i(wide_mode), .a_i(opa), .b_i(opb),
      .v_o(s1_v), .op_o(s1_op), .wide_o(s1_wide), .pp_o(s1_pp));

   mulh_accum #(.XLEN(XLEN)) u_acc (
      .clk(clk), .rst_n(rst_n), .v_i(s1_v), .op_i(s1_op), .wide_i(s1_wide),
      .pp_i(s1_pp), .v_o(s2_v), .op_o(s2_op), .wide_o(s2_wide), .prod_o(s2_prod));

   mulh_format #(.XLEN(XLEN)) u_fmt (
      .clk(clk), .rst_n(rst_n), .v_i(s2_v), .op_i(s2_op), .wide_i(s2_wide),
      .prod_i(s2_prod), .v_o(out_valid), .res_o(out_result), .ill_o(out_illegal));

   logic [1:0] since_rst;
   always_ff @(posedge clk) begin
      if (!rst_n)              since_rst <= 2'd0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

   p_illegal_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_illegal |-> out_valid);
endmodule

// File: tb/tb_mulh_unit.sv
`timescale 1ns/1ps
module tb_mulh_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  op_sel = 2'd0;
   logic        wide_mode = 1'b0;
   logic [63:0] opa = '0, opb = '0;
   logic        out_valid, out_illegal;
   logic [63:0] out_result;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   mulh_unit dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
      .wide_mode(wide_mode), .opa(opa), .opb(opb),
      .out_valid(out_valid), .out_result(out_result), .out_illegal(out_illegal));

   // expected pipeline: slot 2 is due for comparison
   logic        ex_v[3];
   logic        ex_ill[3];
   logic [63:0] ex_res[3];
   string       ex_tag[3];

   function automatic logic [64:0] ref_mul(input logic [1:0] op, input logic wide,
                                           input logic [63:0] a, input logic [63:0] b);
      logic [127:0] pu, ps;
      logic [63:0]  lo;
      pu = {64'd0, a} * {64'd0, b};
      ps = $signed({{64{a[63]}}, a}) * $signed({{64{b[63]}}, b});
      lo = pu[63:0];
      case (op)
         2'd0: return {1'b0, wide ? lo : {{32{lo[31]}}, lo[31:0]}};
         2'd1: return {1'b0, wide ? ps[127:64] : {{32{lo[63]}}, lo[63:32]}};
         2'd2: return {1'b0, wide ? pu[127:64] : {{32{lo[63]}}, lo[63:32]}};
         default: return wide ? {1'b0, {{32{lo[31]}}, lo[31:0]}} : {1'b1, 64'd0};
      endcase
   endfunction

   function automatic string tag_of(input logic [1:0] op, input logic wide);
      if (op == 2'd0) return "R1";
      if (op == 2'd3) return wide ? "R5" : "R6";
      if (!wide) return "R4";
      return (op == 2'd1) ? "R2" : "R3";
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one cycle: compare the due slot, shift, then drive a new issue
   task automatic step(input logic v, input logic [1:0] op, input logic wide,
                       input logic [63:0] a, input logic [63:0] b);
      logic [64:0] r;
      @(negedge clk);
      check("R7 valid", {63'd0, out_valid}, {63'd0, ex_v[2]});
      if (ex_v[2]) begin
         check(ex_tag[2], out_result, ex_res[2]);
         check({ex_tag[2], " R8 illegal"}, {63'd0, out_illegal}, {63'd0, ex_ill[2]});
      end else begin
         check("R8 idle illegal", {63'd0, out_illegal}, 64'd0);
      end
      for (int k = 2; k > 0; k--) begin
         ex_v[k] = ex_v[k-1]; ex_ill[k] = ex_ill[k-1];
         ex_res[k] = ex_res[k-1]; ex_tag[k] = ex_tag[k-1];
      end
      r = ref_mul(op, wide, a, b);
      in_valid = v; op_sel = op; wide_mode = wide; opa = a; opb = b;
      ex_v[0] = v; ex_ill[0] = r[64]; ex_res[0] = r[63:0]; ex_tag[0] = tag_of(op, wide);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin : main
      logic [63:0] a, b;
      logic [1:0]  op;
      logic        w;
      int unsigned seed;
      seed = 32'd20240611;
      void'($urandom(seed));
      for (int k = 0; k < 3; k++) begin
         ex_v[k] = 0; ex_ill[k] = 0; ex_res[k] = '0; ex_tag[k] = "R7";
      end
      // drive random operands during reset: outputs must stay quiet (R9)
      repeat (4) begin
         @(negedge clk);
         in_valid = 1'b1; op_sel = 2'd3; wide_mode = 1'b0;
         opa = {$urandom, $urandom}; opb = {$urandom, $urandom};
         check("R9 valid", {63'd0, out_valid}, 64'd0);
         check("R9 result", out_result, 64'd0);
         check("R9 illegal", {63'd0, out_illegal}, 64'd0);
      end
      @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b1;

      // directed corners
      step(1, 2'd1, 1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000); // R2
      step(1, 2'd1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF); // R2
      step(1, 2'd2, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF); // R3
      step(1, 2'd1, 1, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0003); // R2
      step(1, 2'd2, 0, 64'hFFFF_FFFF_8000_0000, 64'h0000_0000_0000_0002); // R4
      step(1, 2'd1, 0, 64'hFFFF_FFFF_8000_0000, 64'hFFFF_FFFF_8000_0000); // R4
      step(1, 2'd0, 0, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_0000_0002); // R1
      step(1, 2'd0, 1, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321); // R1
      step(1, 2'd3, 1, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001); // R5
      step(1, 2'd3, 0, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0007); // R6
      step(0, 2'd3, 0, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0007); // R8 idle
      step(1, 2'd3, 1, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0007); // R5

      // random stream, back-to-back with occasional bubbles (R7)
      for (int n = 0; n < 3000; n++) begin
         op = 2'($urandom);
         w  = 1'($urandom);
         a  = {$urandom, $urandom};
         b  = {$urandom, $urandom};
         if (!w && ($urandom % 2 == 0)) begin
            a = {{32{a[31]}}, a[31:0]};
            b = {{32{b[31]}}, b[31:0]};
         end
         step(($urandom % 5) != 0, op, w, a, b);
      end
      for (int n = 0; n < 4; n++) step(0, 2'd0, 1, 64'd0, 64'd0);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule